// File: doc/BRIEF.md
# Configurable Timer Input Digital Filter

This block cleans up one asynchronous timer input before a capture channel uses it. The raw pin goes through a two-stage synchroniser. The synchronised level is then sampled on a sampling strobe. The filtered output moves to a new level only after a run of consecutive samples all show that level. The length of the run and the sampling rate are set together by one 4-bit code.

The sampling strobe has one of three sources. It can be every kernel clock cycle. It can be every pulse of a base-rate enable. It can be every 2nd, 4th, 8th, 16th or 32nd pulse of that enable. The base-rate enable is a one-cycle strobe in the kernel clock domain that sets the filter's time base. Writing a new code restarts the filter from a known state, and the output drops to 0. Edge detection, capture prescaling and capture registers sit downstream of this block.

Top module: `cif_filter`

## Requirements
- R1: While `rst` is high on a clock edge, `filt_out` is 0 after that edge.
- R2: Code 0 has no filtering. On each edge where `base_en` is high, `filt_out` takes the synchronised input. With `base_en` pulsing every P cycles, a clean input edge reaches the output 3 to 2+P edges after the input changes.
- R3: Codes 1, 2 and 3 sample on every kernel clock cycle. They need 2, 4 and 8 agreeing samples respectively. A clean input edge reaches `filt_out` exactly N+2 edges after the input changes.
- R4: Codes 4 and 5 sample every 2nd `base_en` pulse. Codes 6 and 7 sample every 4th pulse. Codes 8 and 9 sample every 8th pulse. The even code of each pair needs 6 agreeing samples and the odd code needs 8. With `base_en` pulsing every P cycles and a divide of D, a clean edge appears 3+(N-1)·D·P to 2+N·D·P edges after the input changes.
- R5: Codes 10, 11 and 12 sample every 16th `base_en` pulse. Codes 13, 14 and 15 sample every 32nd pulse. Within each group of three, the codes need 5, 6 and 8 agreeing samples. The latency window is the one given in R4.
- R6: For codes 1 to 15, a pulse of either polarity lasting at most (N-1)·D·P input cycles never changes `filt_out`. A sample equal to the current output clears the partial count.
- R7: On the first edge where `cfg` differs from its value at the previous edge, `filt_out` becomes 0, and the sampling divider and agreement count restart from zero. If the synchronised input is then steadily 1, `filt_out` returns to 1 exactly 1+N·D edges after the change (`base_en` held high).
- R8: For code 0 and codes 4 to 15, `filt_out` does not change on any edge where `base_en` is low and `cfg` is unchanged.
- R9: For codes 1 to 15, two changes of `filt_out` never happen on consecutive edges unless `cfg` changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Kernel clock |
| rst | input | 1 | Synchronous active-high reset |
| base_en | input | 1 | One-cycle strobe marking each base-rate tick |
| cfg | input | 4 | Filter code: selects sampling rate and required run length |
| raw_in | input | 1 | Asynchronous raw timer input |
| filt_out | output | 1 | Registered filtered level |

## Verification
Two functions can act on the same edge: a code change and a sampling decision. The code change wants to force the output to 0, while an agreeing sample may want to keep the output at 1 or set it to 1. The bench provokes this collision on every code. It rewrites `cfg` while the input and output are both high, so the synchronised input disagrees with the forced 0 on the very next sample.

The bench judges the outcome by latency. It expects the drop to 0 exactly one edge after the change. It expects the return to 1 exactly 1+N·D edges later, which is only possible if the divider and counter both restarted on the same edge as the forced clear. A second collision comes from disabling `base_en` under a divided code: input activity must then leave the output frozen until the enable returns.

// File: rtl/cif_pkg.sv
package cif_pkg;

  localparam int CODE_W  = 4;
  localparam int DLOG_W  = 3;
  localparam int NEED_W  = 4;

  typedef struct packed {
    logic              kernel;
    logic [DLOG_W-1:0] div_log;
    logic [NEED_W-1:0] need;
  } mode_t;

  function automatic mode_t decode_mode(input logic [CODE_W-1:0] code);
    mode_t m;
    m.kernel  = 1'b0;
    m.div_log = '0;
    m.need    = 4'd1;
    case (code)
      4'd1:  begin m.kernel = 1'b1; m.need = 4'd2; end
      4'd2:  begin m.kernel = 1'b1; m.need = 4'd4; end
      4'd3:  begin m.kernel = 1'b1; m.need = 4'd8; end
      4'd4:  begin m.div_log = 3'd1; m.need = 4'd6; end
      4'd5:  begin m.div_log = 3'd1; m.need = 4'd8; end
      4'd6:  begin m.div_log = 3'd2; m.need = 4'd6; end
      4'd7:  begin m.div_log = 3'd2; m.need = 4'd8; end
      4'd8:  begin m.div_log = 3'd3; m.need = 4'd6; end
      4'd9:  begin m.div_log = 3'd3; m.need = 4'd8; end
      4'd10: begin m.div_log = 3'd4; m.need = 4'd5; end
      4'd11: begin m.div_log = 3'd4; m.need = 4'd6; end
      4'd12: begin m.div_log = 3'd4; m.need = 4'd8; end
      4'd13: begin m.div_log = 3'd5; m.need = 4'd5; end
      4'd14: begin m.div_log = 3'd5; m.need = 4'd6; end
      4'd15: begin m.div_log = 3'd5; m.need = 4'd8; end
      default: begin m.need = 4'd1; end
    endcase
    return m;
  endfunction

endpackage

// File: rtl/cif_sync.sv
module cif_sync #(
  parameter int LEN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [LEN-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg <= '0;
    else     stg <= {stg[LEN-2:0], din};
  end

  assign dout = stg[LEN-1];

endmodule

// File: rtl/cif_rate.sv
module cif_rate
  import cif_pkg::*;
#(
  parameter int DIV_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              base_en,
  input  logic              kernel,
  input  logic [DLOG_W-1:0] div_log,
  output logic              stb
);

  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] lim;
  logic [DIV_W:0]   span;
  logic             hit;

  always_comb begin
    span = {{DIV_W{1'b0}}, 1'b1} << div_log;
    lim  = DIV_W'(span - 1'b1);
    hit  = (div_cnt == lim);
    if (clr)         stb = 1'b0;
    else if (kernel) stb = 1'b1;
    else             stb = base_en & hit;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      div_cnt <= '0;
    end else if (!kernel && base_en) begin
      div_cnt <= hit ? '0 : div_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/cif_vote.sv
module cif_vote
  import cif_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              stb,
  input  logic              smp,
  input  logic [NEED_W-1:0] need,
  output logic              lvl
);

  logic [CNT_W-1:0] run;
  logic [CNT_W:0]   run_nx;

  assign run_nx = {1'b0, run} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      run <= '0;
      lvl <= 1'b0;
    end else if (stb) begin
      if (smp == lvl) begin
        run <= '0;
      end else if (run_nx >= (CNT_W+1)'(need)) begin
        lvl <= smp;
        run <= '0;
      end else begin
        run <= run_nx[CNT_W-1:0];
      end
    end
  end

endmodule

// File: rtl/cif_filter.sv
module cif_filter
  import cif_pkg::*;
#(
  parameter int SYNC_LEN = 2,
  parameter int DIV_W    = 5,
  parameter int CNT_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_en,
  input  logic [CODE_W-1:0] cfg,
  input  logic              raw_in,
  output logic              filt_out
);

  logic [CODE_W-1:0] cfg_q;
  logic              clr;
  logic              smp;
  logic              stb;
  mode_t             mode;

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else     cfg_q <= cfg;
  end

  assign clr  = (cfg != cfg_q);
  assign mode = decode_mode(cfg_q);

  cif_sync #(.LEN(SYNC_LEN)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (raw_in),
    .dout (smp)
  );

  cif_rate #(.DIV_W(DIV_W)) u_rate (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .base_en (base_en),
    .kernel  (mode.kernel),
    .div_log (mode.div_log),
    .stb     (stb)
  );

  cif_vote #(.CNT_W(CNT_W)) u_vote (
    .clk  (clk),
    .rst  (rst),
    .clr  (clr),
    .stb  (stb),
    .smp  (smp),
    .need (mode.need),
    .lvl  (filt_out)
  );

endmodule

// File: rtl/cif_filter_chk.sv
module cif_filter_chk (
  input logic       clk,
  input logic       rst,
  input logic       base_en,
  input logic [3:0] cfg,
  input logic       filt_out
);

  // R1
  out_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !filt_out);

  // R7
  cfg_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg != $past(cfg)) |=> !filt_out);

  // R8
  base_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (!base_en && cfg == $past(cfg) && (cfg == 4'd0 || cfg >= 4'd4)) |=> $stable(filt_out));

  // R9
  no_double_move_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg != 4'd0 && $stable(cfg) && !$stable(filt_out)) |=> $stable(filt_out));

endmodule

bind cif_filter cif_filter_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .base_en  (base_en),
  .cfg      (cfg),
  .filt_out (filt_out)
);

// File: tb/sim_cif_filter.sv
module sim_cif_filter;

  localparam int CLK_T = 10;

  typedef struct {
    string req;
    bit    val;
    int    lo;
    int    hi;
    int    t0;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       raw = 1'b0;
  logic [3:0] cfg = 4'd0;
  logic       base_lvl = 1'b1;
  logic       gen_on = 1'b0;
  logic       gpulse = 1'b0;
  logic       base_en;
  logic       filt_out;

  int    cyc = 0;
  int    ncmp = 0;
  int    nbad = 0;
  int    gp = 3;
  int    pc = 0;
  bit    armed = 0;
  bit    prev = 0;
  bit    done = 0;
  string quiet_req = "R6";
  exp_t  q[$];

  assign base_en = gen_on ? gpulse : base_lvl;

  cif_filter u0 (
    .clk      (clk),
    .rst      (rst),
    .base_en  (base_en),
    .cfg      (cfg),
    .raw_in   (raw),
    .filt_out (filt_out)
  );

  always #(CLK_T/2) clk = ~clk;
  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    pc = (pc + 1) % gp;
    gpulse = (pc == 0);
  end

  function automatic int need_of(int c);
    case (c)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      4, 6, 8, 11, 14: return 6;
      10, 13: return 5;
      default: return 8;
    endcase
  endfunction

  function automatic int div_of(int c);
    if (c <= 3)  return 1;
    if (c <= 5)  return 2;
    if (c <= 7)  return 4;
    if (c <= 9)  return 8;
    if (c <= 12) return 16;
    return 32;
  endfunction

  function automatic string tag_of(int c);
    if (c == 0) return "R2";
    if (c <= 3) return "R3";
    if (c <= 9) return "R4";
    return "R5";
  endfunction

  task automatic push(string req, bit val, int lo, int hi);
    exp_t e;
    e.req = req; e.val = val; e.lo = lo; e.hi = hi; e.t0 = cyc;
    q.push_back(e);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (armed) begin
      if (filt_out !== prev) begin
        ncmp++;
        if (q.size() == 0) begin
          nbad++;
          $display("FAIL %s: unexpected move to %0b, expected no change (cycle %0d)",
                   quiet_req, filt_out, cyc);
        end else begin
          exp_t e;
          int   lat;
          e   = q.pop_front();
          lat = cyc - e.t0;
          if (filt_out !== e.val || lat < e.lo || lat > e.hi) begin
            nbad++;
            $display("FAIL %s: got val=%0b lat=%0d, expected val=%0b lat %0d..%0d",
                     e.req, filt_out, lat, e.val, e.lo, e.hi);
          end
        end
      end
      prev = filt_out;
    end
  end

  initial begin
    tick(4);
    rst = 1'b0;
    tick(1);
    // R1: output low after reset
    ncmp++;
    if (filt_out !== 1'b0) begin
      nbad++;
      $display("FAIL R1: got %0b, expected 0", filt_out);
    end
    prev  = filt_out;
    armed = 1;

    // R2: code 0, base_en high every cycle
    push("R2", 1'b1, 3, 3);
    raw = 1'b1;
    tick(8);

    for (int c = 1; c < 16; c++) begin
      int n, d, lo, hi, gl;
      n  = need_of(c);
      d  = div_of(c);
      lo = 3 + (n - 1) * d;
      hi = 2 + n * d;
      gl = (n - 1) * d;
      // R7: clear on code change collides with high input
      push("R7", 1'b0, 1, 1);
      push("R7", 1'b1, 1 + n * d, 1 + n * d);
      cfg = 4'(c);
      tick(n * d + 6);
      // clean fall
      push(tag_of(c), 1'b0, lo, hi);
      raw = 1'b0;
      tick(hi + 4);
      // R6: high glitch
      quiet_req = "R6";
      raw = 1'b1;
      tick(gl);
      raw = 1'b0;
      tick(n * d + 8);
      // clean rise
      push(tag_of(c), 1'b1, lo, hi);
      raw = 1'b1;
      tick(hi + 4);
      // R6: low glitch
      raw = 1'b0;
      tick(gl);
      raw = 1'b1;
      tick(n * d + 8);
    end

    // R8: divided code with base_en low stays frozen
    base_lvl = 1'b0;
    push("R7", 1'b0, 1, 1);
    cfg = 4'd5;
    tick(4);
    quiet_req = "R8";
    raw = 1'b0;
    tick(10);
    raw = 1'b1;
    tick(30);
    // R4: base_en pulsing every 3 cycles, divide 2, need 8
    push("R4", 1'b1, 43, 52);
    gen_on = 1'b1;
    tick(60);

    // R2: code 0 with pulsed base_en
    push("R7", 1'b0, 1, 1);
    push("R2", 1'b1, 2, 5);
    cfg = 4'd0;
    tick(10);
    push("R2", 1'b0, 3, 5);
    raw = 1'b0;
    tick(10);

    // R8: code 0 frozen with base_en low
    gen_on = 1'b0;
    base_lvl = 1'b0;
    quiet_req = "R8";
    raw = 1'b1;
    tick(20);
    push("R8", 1'b1, 1, 1);
    base_lvl = 1'b1;
    tick(6);

    while (q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      ncmp++;
      nbad++;
      $display("FAIL %s: got no move, expected val=%0b lat %0d..%0d",
               e.req, e.val, e.lo, e.hi);
    end
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
      $finish;
    end
  end

  initial begin
    #(CLK_T * 150000);
    if (!done) begin
      done = 1;
      ncmp++;
      nbad++;
      $display("FAIL watchdog: got timeout, expected run to finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
      $finish;
    end
  end

endmodule